// File: doc/BRIEF.md
# Instrument status reporting and service-request unit

This block keeps the status register model of an instrument's remote interface. Two event registers gather events: a standard event register set by single-cycle pulses, and an extended event register fed by a per-bit transition filter that watches a live condition vector. Each event register has an enable mask. When the masked contents are nonzero, a summary bit appears in an 8-bit status byte. The same byte also reflects whether the response (output) queue and the error queue hold data.

A service-request enable mask picks which status-byte bits may raise a request. The block forms a level summary (master summary) from the masked bits. It latches a request flag on each rising edge of that summary and drives the service-request line from the flag. A host reads the status byte in two ways. The query view shows the level summary in bit 6 and has no side effect. The serial-poll view shows the request flag in bit 6 and clears the flag. Event registers are read through their outputs and cleared by a read strobe. Command parsing and queue storage sit outside this block.

Top module: `status_report_unit`

## Requirements
- R1: Status-byte bits 7, 1 and 0 are always 0, in both the query view and the poll view.
- R2: Status-byte bit 2 equals the error-queue not-empty flag, and bit 4 equals the output-queue not-empty flag, in the same cycle.
- R3: Status-byte bit 5 is 1 exactly when the standard event register ANDed with its enable mask is nonzero.
- R4: Status-byte bit 3 is 1 exactly when the extended event register ANDed with its enable mask is nonzero.
- R5: In the query view, bit 6 (master summary) is 1 exactly when the status byte with bit 6 excluded, ANDed with the service-request enable mask, is nonzero.
- R6: The request flag is set in the cycle after the master summary rises from 0 to 1. The service-request output and poll-view bit 6 follow the flag.
- R7: The request flag is 0 in the cycle after the master summary is 0.
- R8: A poll strobe clears the request flag at the next edge, and the flag stays 0 while the summary stays high. The query view has no strobe and never changes the flag.
- R9: A status bit whose service-request enable bit is 0 neither sets the summary nor raises a request.
- R10: Each extended bit has a 2-bit filter mode: 0 captures nothing, 1 captures a 0-to-1 change, 2 captures a 1-to-0 change, 3 captures both. A captured change on the condition input sets the matching extended event bit at the next edge.
- R11: A read strobe clears its event register at the next edge. An event arriving in the same cycle as the strobe is kept.
- R12: Reset clears all masks, filter modes, event registers and the request flag, so every output reads 0.
- R13: A standard event pulse sets its register bit, and the bit stays set until a read strobe.
- R14: Mask writes select the target with a 2-bit code: 0 service-request enable, 1 standard event enable, 2 extended event enable. The stored masks are visible on their outputs after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Mask write strobe |
| wr_sel_i | input | 2 | Mask select (0 SRQ enable, 1 standard enable, 2 extended enable) |
| wr_data_i | input | WR_W | Mask write data, low bits used |
| filt_wr_i | input | 1 | Filter mode write strobe |
| filt_idx_i | input | IDX_W | Extended bit whose filter is written |
| filt_mode_i | input | 2 | Filter mode (0 none, 1 rise, 2 fall, 3 both) |
| std_set_i | input | STD_W | Standard event set pulses |
| cond_i | input | EXT_W | Live condition vector |
| outq_nonempty_i | input | 1 | Output queue holds data |
| errq_nonempty_i | input | 1 | Error queue holds data |
| rd_std_i | input | 1 | Standard event read strobe (clears) |
| rd_ext_i | input | 1 | Extended event read strobe (clears) |
| poll_i | input | 1 | Serial-poll strobe (clears request flag) |
| sre_o | output | 8 | Service-request enable mask |
| ese_o | output | STD_W | Standard event enable mask |
| eese_o | output | EXT_W | Extended event enable mask |
| std_evt_o | output | STD_W | Standard event register |
| ext_evt_o | output | EXT_W | Extended event register |
| stb_o | output | 8 | Status byte, bit 6 = master summary |
| poll_byte_o | output | 8 | Status byte, bit 6 = request flag |
| srq_o | output | 1 | Service-request output |

## Verification
The bench builds the block with its defaults: 8 standard event bits and 16 extended event bits. Because the extended width is 16, the top filter index (15) is in reach, so the bench can drive a capture on the highest condition bit. The 8-bit standard width lets the enable mask select any single event. The bench also drives the read strobe and a new event in the same cycle, and polls while the summary stays high.

// File: rtl/srq_pkg.sv
package srq_pkg;

    typedef enum logic [1:0] {
        TF_NONE = 2'd0,
        TF_RISE = 2'd1,
        TF_FALL = 2'd2,
        TF_BOTH = 2'd3
    } tf_mode_e;

    typedef enum logic [1:0] {
        MSEL_SRE  = 2'd0,
        MSEL_ESE  = 2'd1,
        MSEL_EESE = 2'd2
    } mask_sel_e;

    localparam int STB_W    = 8;
    localparam int STB_EAV  = 2;
    localparam int STB_EES  = 3;
    localparam int STB_MAV  = 4;
    localparam int STB_ESB  = 5;
    localparam int STB_SUM  = 6;

    typedef struct packed {
        logic esb;
        logic mav;
        logic ees;
        logic eav;
    } stb_src_t;

    function automatic logic [STB_W-1:0] pack_stb(stb_src_t s, logic b6);
        logic [STB_W-1:0] b;
        b = '0;
        b[STB_EAV] = s.eav;
        b[STB_EES] = s.ees;
        b[STB_MAV] = s.mav;
        b[STB_ESB] = s.esb;
        b[STB_SUM] = b6;
        return b;
    endfunction

    function automatic logic tf_hit(tf_mode_e m, logic rise, logic fall);
        return (rise && (m == TF_RISE || m == TF_BOTH)) ||
               (fall && (m == TF_FALL || m == TF_BOTH));
    endfunction

endpackage

// File: rtl/srq_event_reg.sv
module srq_event_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] q_o,
    output logic         sum_o
);

    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= (clr_i ? '0 : q) | set_i;
        end
    end

    assign q_o   = q;
    assign sum_o = |(q & mask_i);

    // a set bit is present after the edge, even alongside a clear
    assert_set_kept_R11: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((q & $past(set_i)) == $past(set_i)));

    // a clear with no new events empties the register
    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (rst)
        (clr_i && set_i == '0) |=> (q == '0));

    // without a clear, bits never drop
    assert_sticky_R13: assert property (@(posedge clk) disable iff (rst)
        (!clr_i) |=> ((q & $past(q)) == $past(q)));

endmodule

// File: rtl/srq_xfilter.sv
module srq_xfilter
    import srq_pkg::*;
#(
    parameter int W     = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     cond_i,
    input  logic             wr_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [1:0]       mode_i,
    output logic [W-1:0]     set_o
);

    logic [W-1:0] cond_q;

    always_ff @(posedge clk) begin
        if (rst) cond_q <= '0;
        else     cond_q <= cond_i;
    end

    for (genvar k = 0; k < W; k++) begin : g_bit
        tf_mode_e mode_q;
        logic     rise;
        logic     fall;

        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q <= TF_NONE;
            end else if (wr_i && idx_i == IDX_W'(k)) begin
                mode_q <= tf_mode_e'(mode_i);
            end
        end

        assign rise     = cond_i[k] & ~cond_q[k];
        assign fall     = ~cond_i[k] & cond_q[k];
        assign set_o[k] = tf_hit(mode_q, rise, fall);

        // a bit in capture-nothing mode never produces an event
        assert_none_quiet_R10: assert property (@(posedge clk) disable iff (rst)
            (mode_q == TF_NONE) |-> !set_o[k]);
    end

endmodule

// File: rtl/srq_status_core.sv
module srq_status_core
    import srq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  stb_src_t         src_i,
    input  logic [STB_W-1:0] sre_i,
    input  logic             poll_i,
    output logic [STB_W-1:0] stb_o,
    output logic [STB_W-1:0] poll_o,
    output logic             rqs_o
);

    logic [STB_W-1:0] base;
    logic             mss;
    logic             mss_d;
    logic             rqs;
    logic             mss_rise;

    assign base     = pack_stb(src_i, 1'b0);
    assign mss      = |(base & sre_i);
    assign mss_rise = mss & ~mss_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            mss_d <= 1'b0;
            rqs   <= 1'b0;
        end else begin
            mss_d <= mss;
            rqs   <= mss & (mss_rise | (rqs & ~poll_i));
        end
    end

    assign stb_o  = pack_stb(src_i, mss);
    assign poll_o = pack_stb(src_i, rqs);
    assign rqs_o  = rqs;

    assert_fixed_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (stb_o[7] == 1'b0 && stb_o[1:0] == 2'b00 &&
         poll_o[7] == 1'b0 && poll_o[1:0] == 2'b00));

    assert_rqs_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
        mss_rise |=> rqs_o);

    assert_rqs_drop_R7: assert property (@(posedge clk) disable iff (rst)
        !stb_o[STB_SUM] |=> !rqs_o);

    assert_poll_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (poll_i && !mss_rise) |=> !rqs_o);

endmodule

// File: rtl/status_report_unit.sv
module status_report_unit
    import srq_pkg::*;
#(
    parameter  int STD_W = 8,
    parameter  int EXT_W = 16,
    localparam int WR_W  = (EXT_W > STD_W) ? ((EXT_W > 8) ? EXT_W : 8)
                                           : ((STD_W > 8) ? STD_W : 8),
    localparam int IDX_W = (EXT_W > 1) ? $clog2(EXT_W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [WR_W-1:0]  wr_data_i,
    input  logic             filt_wr_i,
    input  logic [IDX_W-1:0] filt_idx_i,
    input  logic [1:0]       filt_mode_i,
    input  logic [STD_W-1:0] std_set_i,
    input  logic [EXT_W-1:0] cond_i,
    input  logic             outq_nonempty_i,
    input  logic             errq_nonempty_i,
    input  logic             rd_std_i,
    input  logic             rd_ext_i,
    input  logic             poll_i,
    output logic [7:0]       sre_o,
    output logic [STD_W-1:0] ese_o,
    output logic [EXT_W-1:0] eese_o,
    output logic [STD_W-1:0] std_evt_o,
    output logic [EXT_W-1:0] ext_evt_o,
    output logic [7:0]       stb_o,
    output logic [7:0]       poll_byte_o,
    output logic             srq_o
);

    logic [7:0]       sre_q;
    logic [STD_W-1:0] ese_q;
    logic [EXT_W-1:0] eese_q;
    logic [EXT_W-1:0] ext_set;
    logic             esb;
    logic             ees;
    stb_src_t         src;

    always_ff @(posedge clk) begin
        if (rst) begin
            sre_q  <= '0;
            ese_q  <= '0;
            eese_q <= '0;
        end else if (wr_en_i) begin
            case (mask_sel_e'(wr_sel_i))
                MSEL_SRE:  sre_q  <= wr_data_i[7:0];
                MSEL_ESE:  ese_q  <= wr_data_i[STD_W-1:0];
                MSEL_EESE: eese_q <= wr_data_i[EXT_W-1:0];
                default:   ;
            endcase
        end
    end

    srq_event_reg #(.W(STD_W)) u_std (
        .clk    (clk),
        .rst    (rst),
        .set_i  (std_set_i),
        .clr_i  (rd_std_i),
        .mask_i (ese_q),
        .q_o    (std_evt_o),
        .sum_o  (esb)
    );

    srq_xfilter #(.W(EXT_W), .IDX_W(IDX_W)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .cond_i (cond_i),
        .wr_i   (filt_wr_i),
        .idx_i  (filt_idx_i),
        .mode_i (filt_mode_i),
        .set_o  (ext_set)
    );

    srq_event_reg #(.W(EXT_W)) u_ext (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ext_set),
        .clr_i  (rd_ext_i),
        .mask_i (eese_q),
        .q_o    (ext_evt_o),
        .sum_o  (ees)
    );

    assign src.esb = esb;
    assign src.mav = outq_nonempty_i;
    assign src.ees = ees;
    assign src.eav = errq_nonempty_i;

    srq_status_core u_core (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src),
        .sre_i  (sre_q),
        .poll_i (poll_i),
        .stb_o  (stb_o),
        .poll_o (poll_byte_o),
        .rqs_o  (srq_o)
    );

    assign sre_o  = sre_q;
    assign ese_o  = ese_q;
    assign eese_o = eese_q;

    // queue flags reach the byte with no register in between
    assert_queue_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (stb_o[STB_EAV] == errq_nonempty_i) && (stb_o[STB_MAV] == outq_nonempty_i));

    // the request line never stands without a summary behind it
    assert_srq_needs_sum_R9: assert property (@(posedge clk) disable iff (rst)
        srq_o |-> $past(stb_o[STB_SUM]));

endmodule

// File: tb/status_report_unit_tb.sv
`timescale 1ns/1ps
module status_report_unit_tb;

    localparam int STD_W = 8;
    localparam int EXT_W = 16;
    localparam int WR_W  = 16;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_en_i;
    logic [1:0]       wr_sel_i;
    logic [WR_W-1:0]  wr_data_i;
    logic             filt_wr_i;
    logic [IDX_W-1:0] filt_idx_i;
    logic [1:0]       filt_mode_i;
    logic [STD_W-1:0] std_set_i;
    logic [EXT_W-1:0] cond_i;
    logic             outq_nonempty_i;
    logic             errq_nonempty_i;
    logic             rd_std_i;
    logic             rd_ext_i;
    logic             poll_i;
    logic [7:0]       sre_o;
    logic [STD_W-1:0] ese_o;
    logic [EXT_W-1:0] eese_o;
    logic [STD_W-1:0] std_evt_o;
    logic [EXT_W-1:0] ext_evt_o;
    logic [7:0]       stb_o;
    logic [7:0]       poll_byte_o;
    logic             srq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    status_report_unit #(.STD_W(STD_W), .EXT_W(EXT_W)) u_dut (
        .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .filt_wr_i(filt_wr_i), .filt_idx_i(filt_idx_i),
        .filt_mode_i(filt_mode_i), .std_set_i(std_set_i), .cond_i(cond_i),
        .outq_nonempty_i(outq_nonempty_i), .errq_nonempty_i(errq_nonempty_i),
        .rd_std_i(rd_std_i), .rd_ext_i(rd_ext_i), .poll_i(poll_i),
        .sre_o(sre_o), .ese_o(ese_o), .eese_o(eese_o), .std_evt_o(std_evt_o),
        .ext_evt_o(ext_evt_o), .stb_o(stb_o), .poll_byte_o(poll_byte_o),
        .srq_o(srq_o)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en_i = 0; wr_sel_i = 0; wr_data_i = 0; filt_wr_i = 0;
        filt_idx_i = 0; filt_mode_i = 0; std_set_i = 0; cond_i = 0;
        outq_nonempty_i = 0; errq_nonempty_i = 0; rd_std_i = 0; rd_ext_i = 0;
        poll_i = 0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic wr_mask(input logic [1:0] sel, input logic [WR_W-1:0] d);
        wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
        step();
        wr_en_i = 0;
    endtask

    task automatic wr_filt(input int idx, input logic [1:0] m);
        filt_wr_i = 1; filt_idx_i = IDX_W'(idx); filt_mode_i = m;
        step();
        filt_wr_i = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R12 stb after reset", 32'(stb_o), 0);
        chk("R12 poll byte after reset", 32'(poll_byte_o), 0);
        chk("R12 srq after reset", 32'(srq_o), 0);
        chk("R12 events after reset", 32'({std_evt_o, ext_evt_o}), 0);
        chk("R12 masks after reset", 32'({sre_o, ese_o}) | 32'(eese_o), 0);
    endtask

    task automatic t_masks();
        do_reset();
        wr_mask(2'd0, 16'h00A5);
        wr_mask(2'd1, 16'h003C);
        wr_mask(2'd2, 16'hBEEF);
        chk("R14 sre", 32'(sre_o), 32'hA5);
        chk("R14 ese", 32'(ese_o), 32'h3C);
        chk("R14 eese", 32'(eese_o), 32'hBEEF);
    endtask

    task automatic t_queues();
        do_reset();
        errq_nonempty_i = 1; #1;
        chk("R2 error queue bit", 32'(stb_o), 32'h04);
        outq_nonempty_i = 1; #1;
        chk("R2 output queue bit", 32'(stb_o), 32'h14);
        chk("R1 poll view fixed bits", 32'(poll_byte_o & 8'h83), 0);
        chk("R1 query view fixed bits", 32'(stb_o & 8'h83), 0);
        step();
        chk("R9 no request with zero enable", 32'(srq_o), 0);
        errq_nonempty_i = 0; #1;
        chk("R2 error queue cleared", 32'(stb_o), 32'h10);
    endtask

    task automatic t_std();
        do_reset();
        std_set_i = 8'h08; step(); std_set_i = 0;
        chk("R13 pulse latched", 32'(std_evt_o), 32'h08);
        chk("R3 ESB masked off", 32'(stb_o[5]), 0);
        step(); step();
        chk("R13 bit held", 32'(std_evt_o), 32'h08);
        wr_mask(2'd1, 16'h0004);
        chk("R3 ESB non-matching mask", 32'(stb_o[5]), 0);
        wr_mask(2'd1, 16'h0008);
        chk("R3 ESB matching mask", 32'(stb_o[5]), 1);
        rd_std_i = 1; std_set_i = 8'h02; step();
        rd_std_i = 0; std_set_i = 0;
        chk("R11 read clears, same-cycle event kept", 32'(std_evt_o), 32'h02);
        chk("R3 ESB after clear", 32'(stb_o[5]), 0);
        rd_std_i = 1; step(); rd_std_i = 0;
        chk("R11 plain read clears", 32'(std_evt_o), 0);
    endtask

    task automatic t_filter();
        do_reset();
        wr_mask(2'd2, 16'hFFFF);
        wr_filt(0, 2'd1);
        wr_filt(1, 2'd2);
        wr_filt(2, 2'd3);
        wr_filt(3, 2'd0);
        wr_filt(15, 2'd1);
        cond_i = 16'h800F; step();
        chk("R10 rising captures", 32'(ext_evt_o), 32'h8005);
        chk("R4 EES set", 32'(stb_o[3]), 1);
        rd_ext_i = 1; step(); rd_ext_i = 0;
        chk("R11 extended read clears", 32'(ext_evt_o), 0);
        cond_i = 16'h0000; step();
        chk("R10 falling captures", 32'(ext_evt_o), 32'h0006);
        wr_mask(2'd2, 16'h0001);
        chk("R4 EES masked off", 32'(stb_o[3]), 0);
    endtask

    task automatic t_request();
        do_reset();
        wr_mask(2'd0, 16'h0004);
        errq_nonempty_i = 1; #1;
        chk("R5 summary in query view", 32'(stb_o), 32'h44);
        chk("R6 flag not yet set", 32'(srq_o), 0);
        step();
        chk("R6 request raised", 32'(srq_o), 1);
        chk("R6 poll view bit 6", 32'(poll_byte_o), 32'h44);
        step();
        chk("R8 query view leaves flag", 32'(srq_o), 1);
        poll_i = 1; step(); poll_i = 0;
        chk("R8 poll clears request", 32'(srq_o), 0);
        chk("R8 poll view after clear", 32'(poll_byte_o), 32'h04);
        chk("R5 summary still high", 32'(stb_o[6]), 1);
        step();
        chk("R8 no re-raise while summary high", 32'(srq_o), 0);
        errq_nonempty_i = 0; step();
        errq_nonempty_i = 1; step();
        chk("R6 re-armed by new rise", 32'(srq_o), 1);
        errq_nonempty_i = 0; #1;
        chk("R7 flag still set before edge", 32'(srq_o), 1);
        step();
        chk("R7 flag dropped with summary", 32'(srq_o), 0);
    endtask

    task automatic t_mask_srq();
        do_reset();
        wr_mask(2'd0, 16'h0010);
        errq_nonempty_i = 1; step(); step();
        chk("R9 masked error no summary", 32'(stb_o[6]), 0);
        chk("R9 masked error no request", 32'(srq_o), 0);
        outq_nonempty_i = 1; step();
        chk("R9 enabled bit requests", 32'(srq_o), 1);
    endtask

    initial begin
        t_reset();
        t_masks();
        t_queues();
        t_std();
        t_filter();
        t_request();
        t_mask_srq();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule